// File: doc/BRIEF.md
# Compare Timer Frame with Self-Rearming Channel

This block is one timer frame behind a 32-bit register bus. It does not count by itself. It watches a free-running 64-bit count that arrives on an input port and drives one level-sensitive interrupt line.

In compare mode, software loads an absolute 64-bit deadline. It can write the deadline as two words, or as a signed 32-bit offset from the present count. In auto-increment mode, the block re-arms its own 64-bit target from a 32-bit reload value every time the count reaches that target. Each such event raises a sticky flag, which software acknowledges by writing zero to it.

The frame also provides a configuration word, a frequency word that software may use freely, and a bank of read-only identification words. Reads are answered exactly one cycle after the request.

Top module: `cmp_timer_frame`

## Requirements
- R1: Reset is synchronous and active-high. Afterwards the control word, the compare value, the frequency word, the auto target, the reload value and the auto control word all read as zero, and `irq_o` is low.
- R2: Offsets 0x00 and 0x04 return the low and high halves of the count. Offset 0x50 returns 1 in bits [3:0]. Offsets 0xFD0 through 0xFFC return identification word i = `ID_BASE` + i, where i = (offset − 0xFD0)/4.
- R3: Writes to read-only offsets (count, auto target, configuration, identification) are ignored, and so are writes to unmapped or unaligned offsets. Reads of unmapped or unaligned offsets return zero.
- R4: Control word at 0x2C: bit 0 is the enable and bit 1 is the interrupt mask. Only these two bits store a value. Bit 2 reads the live status, and bits [31:3] read zero.
- R5: Compare mode (auto EN clear): the status is high exactly when the enable is set and the count is at least the 64-bit compare value, compared unsigned. `irq_o` reflects this in the same cycle as the count that satisfies it.
- R6: `irq_o` equals the status AND NOT the mask.
- R7: Offset 0x28 reads the low 32 bits of (compare − count). A write to 0x28 loads compare = count + the written value, sign-extended to 64 bits.
- R8: Auto control at 0x4C: bit 0 (EN) is read/write. Bit 1 (CLR) is cleared by writing 0 to it and is unchanged when 1 is written. Both bits read back.
- R9: The auto target (0x40 low, 0x44 high) is loaded with count + reload (reload at 0x48) on a write in two cases. The first is a write that changes EN while the enable is set. The second is a write that sets the enable from 0 to 1 while EN is set.
- R10: At every clock edge where EN and the enable are both set and the count is at least the target, CLR becomes 1 and the target becomes count + reload. This takes precedence over a same-cycle CLR clear.
- R11: When EN is set, the status and the interrupt follow CLR (gated by the enable) instead of the compare condition.
- R12: A read request yields `rd_valid` and `rd_data` in the next cycle. The data reflects the state and count of the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Free-running count value |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is an auto-increment hit with its re-arm. That requires EN and the enable to be set in the right order, so that the target is captured from a known count. The count then has to be brought to exactly one below the target and then to the target itself. The bench drives the count port directly and holds it still between steps, so the re-armed target (count + reload) is a known number. That number is then read back alongside the sticky flag, both before and after acknowledging.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;
    localparam int N_ID   = 12;
    localparam logic [ADDR_W-1:0] ID_FIRST_ADDR = 12'hFD0;
    localparam logic [DATA_W-1:0] AI_IMPL_CODE  = 32'd1;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MASK_BIT = 1;
    localparam int AI_EN_BIT    = 0;
    localparam int AI_CLR_BIT   = 1;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CNT_LO, SEL_CNT_HI, SEL_FREQ, SEL_CMP_LO, SEL_CMP_HI,
        SEL_REL, SEL_CTL, SEL_AI_LO, SEL_AI_HI, SEL_RELOAD, SEL_AICTL,
        SEL_CFG, SEL_ID
    } sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        sel_e              sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        sel_e s;
        case (a)
            12'h000: s = SEL_CNT_LO;
            12'h004: s = SEL_CNT_HI;
            12'h010: s = SEL_FREQ;
            12'h020: s = SEL_CMP_LO;
            12'h024: s = SEL_CMP_HI;
            12'h028: s = SEL_REL;
            12'h02C: s = SEL_CTL;
            12'h040: s = SEL_AI_LO;
            12'h044: s = SEL_AI_HI;
            12'h048: s = SEL_RELOAD;
            12'h04C: s = SEL_AICTL;
            12'h050: s = SEL_CFG;
            default: s = (a >= ID_FIRST_ADDR && a[1:0] == 2'b00) ? SEL_ID : SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] sext32(input logic [DATA_W-1:0] v);
        return {{(CNT_W-DATA_W){v[DATA_W-1]}}, v};
    endfunction
endpackage

// File: rtl/ctf_compare.sv
module ctf_compare
    import ctf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cval
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cval <= '0;
        end else if (op.wr) begin
            case (op.sel)
                SEL_CMP_LO: cval[DATA_W-1:0]     <= op.wdata;
                SEL_CMP_HI: cval[CNT_W-1:DATA_W] <= op.wdata;
                SEL_REL:    cval                 <= cnt + sext32(op.wdata);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctf_autoinc.sv
module ctf_autoinc
    import ctf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              enable_q,
    input  logic              enable_rise,
    output logic [CNT_W-1:0]  target,
    output logic [DATA_W-1:0] reload,
    output logic              ai_en,
    output logic              ai_clr
);
    logic ctl_wr, en_toggle, rearm, hit;
    logic [CNT_W-1:0] next_target;

    always_comb begin
        ctl_wr      = op.wr && (op.sel == SEL_AICTL);
        en_toggle   = ctl_wr && (op.wdata[AI_EN_BIT] != ai_en);
        rearm       = (en_toggle && enable_q) || (enable_rise && ai_en);
        hit         = ai_en && enable_q && (cnt >= target);
        next_target = cnt + {{(CNT_W-DATA_W){1'b0}}, reload};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target <= '0;
            reload <= '0;
            ai_en  <= 1'b0;
            ai_clr <= 1'b0;
        end else begin
            if (op.wr && op.sel == SEL_RELOAD)
                reload <= op.wdata;
            if (ctl_wr)
                ai_en <= op.wdata[AI_EN_BIT];
            if (hit)
                ai_clr <= 1'b1;
            else if (ctl_wr && !op.wdata[AI_CLR_BIT])
                ai_clr <= 1'b0;
            if (hit || rearm)
                target <= next_target;
        end
    end
endmodule

// File: rtl/ctf_idrom.sv
module ctf_idrom
    import ctf_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_BASE = 32'h0000_00A0
) (
    input  logic [ADDR_W-3:0]  word_addr,
    output logic [DATA_W-1:0]  word
);
    localparam logic [ADDR_W-3:0] FIRST = ID_FIRST_ADDR[ADDR_W-1:2];
    localparam int IW = $clog2(N_ID);

    logic [DATA_W-1:0] words [N_ID];
    logic [ADDR_W-3:0] idx;

    for (genvar i = 0; i < N_ID; i++) begin : g_id
        assign words[i] = ID_BASE + DATA_W'(i);
    end

    always_comb begin
        idx  = word_addr - FIRST;
        word = (idx < ADDR_W'(N_ID)) ? words[idx[IW-1:0]] : '0;
    end
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
    import ctf_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_BASE = 32'h0000_00A0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    bus_op_t           op;
    logic              ctl_enable_q, ctl_mask_q;
    logic [DATA_W-1:0] freq_q;
    logic [CNT_W-1:0]  cval;
    logic [CNT_W-1:0]  ai_target;
    logic [DATA_W-1:0] ai_reload;
    logic              ai_en, ai_clr;
    logic              ctl_wr, enable_rise, status;
    logic [DATA_W-1:0] rel_view, id_word, rd_next;

    always_comb begin
        op.wr    = req_valid && req_write;
        op.rd    = req_valid && !req_write;
        op.sel   = decode(req_addr);
        op.wdata = req_wdata;
        ctl_wr      = op.wr && (op.sel == SEL_CTL);
        enable_rise = ctl_wr && req_wdata[CTL_EN_BIT] && !ctl_enable_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_enable_q <= 1'b0;
            ctl_mask_q   <= 1'b0;
            freq_q       <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_enable_q <= req_wdata[CTL_EN_BIT];
                ctl_mask_q   <= req_wdata[CTL_MASK_BIT];
            end
            if (op.wr && op.sel == SEL_FREQ)
                freq_q <= req_wdata;
        end
    end

    ctf_compare u_cmp (
        .clk(clk), .rst(rst), .op(op), .cnt(cnt_i), .cval(cval)
    );

    ctf_autoinc u_ai (
        .clk(clk), .rst(rst), .op(op), .cnt(cnt_i),
        .enable_q(ctl_enable_q), .enable_rise(enable_rise),
        .target(ai_target), .reload(ai_reload),
        .ai_en(ai_en), .ai_clr(ai_clr)
    );

    ctf_idrom #(.ID_BASE(ID_BASE)) u_id (
        .word_addr(req_addr[ADDR_W-1:2]), .word(id_word)
    );

    always_comb begin
        status   = ctl_enable_q && (ai_en ? ai_clr : (cnt_i >= cval));
        irq_o    = status && !ctl_mask_q;
        rel_view = cval[DATA_W-1:0] - cnt_i[DATA_W-1:0];
        case (op.sel)
            SEL_CNT_LO: rd_next = cnt_i[DATA_W-1:0];
            SEL_CNT_HI: rd_next = cnt_i[CNT_W-1:DATA_W];
            SEL_FREQ:   rd_next = freq_q;
            SEL_CMP_LO: rd_next = cval[DATA_W-1:0];
            SEL_CMP_HI: rd_next = cval[CNT_W-1:DATA_W];
            SEL_REL:    rd_next = rel_view;
            SEL_CTL:    rd_next = {{(DATA_W-3){1'b0}}, status, ctl_mask_q, ctl_enable_q};
            SEL_AI_LO:  rd_next = ai_target[DATA_W-1:0];
            SEL_AI_HI:  rd_next = ai_target[CNT_W-1:DATA_W];
            SEL_RELOAD: rd_next = ai_reload;
            SEL_AICTL:  rd_next = {{(DATA_W-2){1'b0}}, ai_clr, ai_en};
            SEL_CFG:    rd_next = AI_IMPL_CODE;
            SEL_ID:     rd_next = id_word;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= op.rd;
            rd_data  <= op.rd ? rd_next : '0;
        end
    end
endmodule

// File: rtl/ctf_checks.sv
module ctf_checks
    import ctf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt_i,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_o,
    input logic              enable_q,
    input logic              ai_en,
    input logic              ai_clr,
    input logic [CNT_W-1:0]  ai_target,
    input logic [DATA_W-1:0] ai_reload
);
    logic clr_wr0, ai_hit;
    always_comb begin
        clr_wr0 = req_valid && req_write && req_addr == 12'h04C && !req_wdata[AI_CLR_BIT];
        ai_hit  = ai_en && enable_q && (cnt_i >= ai_target);
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable_q |-> !irq_o); // R5
    AST_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        ai_clr && !clr_wr0 |=> ai_clr); // R8
    AST_CLR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !ai_clr && !ai_hit |=> !ai_clr); // R10
    AST_REARM_TARGET: assert property (@(posedge clk) disable iff (rst)
        ai_hit |=> ai_clr && ai_target == $past(cnt_i) + {32'b0, $past(ai_reload)}); // R10
    AST_CFG_READ: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && req_addr == 12'h050 |=> rd_data == 32'd1); // R2
    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write && req_addr == 12'h02C |=> rd_data[31:3] == 29'd0); // R4
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write |=> rd_valid); // R12
endmodule

bind cmp_timer_frame ctf_checks u_chk (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o),
    .enable_q(ctl_enable_q), .ai_en(ai_en), .ai_clr(ai_clr),
    .ai_target(ai_target), .ai_reload(ai_reload)
);

// File: tb/cmp_timer_frame_bench.sv
`timescale 1ns/1ps
module cmp_timer_frame_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid, irq_o;
    logic [31:0] rd_data;

    int vectors = 0, miscompares = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #10 clk = ~clk;

    cmp_timer_frame u_cmp_timer_frame (
        .clk(clk), .rst(rst), .cnt_i(cnt), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
    );

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R12: unexpected read response act=%h exp=none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    miscompares++;
                    $display("FAIL %s: read act=%h exp=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        vectors++;
        if (irq_o !== e) begin
            miscompares++;
            $display("FAIL %s: irq act=%b exp=%b", t, irq_o, e);
        end
    endtask

    task automatic set_cnt(input logic [63:0] v);
        cnt = v;
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1");
        bus_rd(12'h02C, 32'h0, "R1");
        bus_rd(12'h020, 32'h0, "R1");
        bus_rd(12'h010, 32'h0, "R1");
        bus_rd(12'h048, 32'h0, "R1");
        bus_rd(12'h04C, 32'h0, "R1");
        // R2 fixed words and count
        bus_rd(12'h050, 32'h1, "R2");
        bus_rd(12'hFD0, 32'hA0, "R2");
        bus_rd(12'hFFC, 32'hAB, "R2");
        cnt = 64'h1_0000_0100;
        bus_rd(12'h000, 32'h100, "R2");
        bus_rd(12'h004, 32'h1, "R2");
        // R3 unmapped / unaligned
        bus_rd(12'h030, 32'h0, "R3");
        bus_rd(12'h022, 32'h0, "R3");
        bus_wr(12'h010, 32'hCAFE);
        bus_rd(12'h010, 32'hCAFE, "R2");
        // R5 compare mode
        bus_wr(12'h024, 32'h1);
        bus_wr(12'h020, 32'h200);
        bus_wr(12'h02C, 32'h1);
        chk_irq(1'b0, "R5");
        bus_rd(12'h02C, 32'h1, "R4");
        bus_rd(12'h028, 32'h100, "R7");
        set_cnt(64'h1_0000_01FF);
        chk_irq(1'b0, "R5");
        cnt = 64'h1_0000_0200;
        chk_irq(1'b1, "R5");
        bus_rd(12'h02C, 32'h5, "R4");
        // R6 mask
        bus_wr(12'h02C, 32'h3);
        chk_irq(1'b0, "R6");
        bus_rd(12'h02C, 32'h7, "R6");
        bus_wr(12'h02C, 32'h1);
        chk_irq(1'b1, "R6");
        // R7 relative writes
        bus_wr(12'h028, 32'hFFFF_FFF0);
        bus_rd(12'h020, 32'h1F0, "R7");
        bus_rd(12'h024, 32'h1, "R7");
        chk_irq(1'b1, "R7");
        bus_wr(12'h028, 32'h10);
        chk_irq(1'b0, "R7");
        bus_rd(12'h028, 32'h10, "R7");
        // R5 unsigned compare
        bus_wr(12'h024, 32'h8000_0000);
        chk_irq(1'b0, "R5");
        bus_wr(12'h024, 32'h0);
        chk_irq(1'b1, "R5");
        // R3 read-only writes ignored
        bus_wr(12'h000, 32'h1234);
        bus_rd(12'h000, 32'h200, "R3");
        bus_wr(12'h050, 32'hF);
        bus_rd(12'h050, 32'h1, "R3");
        bus_wr(12'h040, 32'h5);
        bus_rd(12'h040, 32'h0, "R3");
        bus_wr(12'hFD4, 32'h0);
        bus_rd(12'hFD4, 32'hA1, "R3");
        // R4 only two bits store
        bus_wr(12'h02C, 32'hFFFF_FFFF);
        bus_rd(12'h02C, 32'h7, "R4");
        chk_irq(1'b0, "R6");
        bus_wr(12'h02C, 32'h1);
        // R9 arm on EN set while enabled
        bus_wr(12'h048, 32'h40);
        bus_wr(12'h04C, 32'h1);
        chk_irq(1'b0, "R11");
        bus_rd(12'h040, 32'h240, "R9");
        bus_rd(12'h044, 32'h1, "R9");
        bus_rd(12'h04C, 32'h1, "R8");
        bus_rd(12'h02C, 32'h1, "R11");
        // R10 hit
        set_cnt(64'h1_0000_023F);
        chk_irq(1'b0, "R10");
        set_cnt(64'h1_0000_0240);
        chk_irq(1'b1, "R10");
        bus_rd(12'h040, 32'h280, "R10");
        bus_rd(12'h04C, 32'h3, "R10");
        bus_rd(12'h02C, 32'h5, "R11");
        // R8 CLR write semantics
        bus_wr(12'h04C, 32'h3);
        bus_rd(12'h04C, 32'h3, "R8");
        chk_irq(1'b1, "R8");
        bus_wr(12'h04C, 32'h1);
        chk_irq(1'b0, "R8");
        bus_rd(12'h04C, 32'h1, "R8");
        bus_rd(12'h040, 32'h280, "R9");
        // R9 arm on enable rise while EN set
        bus_wr(12'h02C, 32'h0);
        cnt = 64'h1_0000_0300;
        chk_irq(1'b0, "R11");
        bus_rd(12'h04C, 32'h1, "R10");
        bus_wr(12'h02C, 32'h1);
        bus_rd(12'h040, 32'h340, "R9");
        chk_irq(1'b0, "R11");
        // back to compare mode
        bus_wr(12'h04C, 32'h0);
        chk_irq(1'b1, "R11");
        bus_rd(12'h040, 32'h340, "R9");
        repeat (3) @(negedge clk);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R12: pending reads act=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule